// File: doc/BRIEF.md
# Page-Mode Write Load Controller

This block sits between a host that writes through a parallel strobe interface (active-low chip enable, write enable and output enable) and the programming engine of a non-volatile array. Each host write cycle delivers one byte into a page buffer. The first accepted byte of a page fixes the page number, which is the upper address bits. Later bytes must carry the same page number or they are dropped. The address is taken when the write cycle opens, which is on the later of the two enable falling edges. The data is taken when the cycle closes, which is on the earlier of the two rising edges.

A load window timer restarts on every write-enable falling edge. When it runs out with bytes in the buffer, the block issues a one-cycle commit request and then holds a busy flag for a fixed programming time. The buffered bytes, their valid flags and the page number stay on the outputs for the programming engine to consume. The last accepted address and byte are held for status polling. Both durations are parameters counted in clock cycles. The strobes are taken to be already synchronous to the clock.

Top module: `page_load_ctrl`

## Requirements
- R1: A write cycle exists only while ce_n and we_n are both low and oe_n is high; strobe activity with oe_n low loads nothing.
- R2: The byte address is the value of addr in the first clock cycle in which the write condition holds, that is, at the later of the two enable falling edges; later addr changes in the cycle are ignored.
- R3: The byte data is the value of din in the last clock cycle in which the write condition holds, that is, before the earlier of the two enable rising edges.
- R4: The first accepted load after reset or after a commit opens a new page. Its page number is addr[14:7], all other valid flags are cleared, and offset addr[6:0] selects valid flag bit i and byte page_data[8*i+7:8*i]. A reload of an offset overwrites that byte.
- R5: While a page is open, a load whose addr[14:7] differs from the open page is dropped and sets page_err. page_err stays set until the first load of the next page clears it.
- R6: A commit happens exactly LOAD_WIN cycles after the most recent clock edge at which we_n was sampled low after being sampled high. Every such edge restarts the window, so a chain of loads has no overall length limit.
- R7: commit is a single-cycle pulse that occurs only with at least one valid flag set. commit_page shows the page number, and page_valid and page_data stay unchanged through commit.
- R8: busy rises in the same cycle as commit and stays high for exactly PROG_CYC cycles. busy is low after reset.
- R9: While busy is high, write strobes change neither the page buffer, the valid flags, nor the last-write outputs.
- R10: last_addr and last_data show the address and byte of the most recent accepted load. A dropped load does not change them.
- R11: A page accepts all 128 offsets, and every byte is committed with its valid flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; must be high for a write |
| addr | input | 15 | Byte address |
| din | input | 8 | Write data |
| page_data | output | 1024 | Buffered page, byte i at bits 8*i+7:8*i |
| page_valid | output | 128 | One flag per buffered byte |
| commit_page | output | 8 | Page number of the buffered page |
| commit | output | 1 | One-cycle request to program the page |
| busy | output | 1 | Programming in progress |
| page_err | output | 1 | Sticky flag: a load with a foreign page number was dropped |
| last_addr | output | 15 | Address of the last accepted load |
| last_data | output | 8 | Byte of the last accepted load |

## Verification
The bench builds the block with LOAD_WIN set to 20 and PROG_CYC set to 50. At these values a whole write cycle of about six clocks fits well inside one window, so chains of loads, the window retrigger after a gap and a complete 128-byte page all complete in a few thousand cycles. The programming time is also long enough for a full strobe cycle to fall inside busy. The exact commit delay is measured from the last sampled write-enable falling edge, and the busy length is counted cycle by cycle. Both values can be reached only because the two durations are this short.

// File: rtl/plc_pkg.sv
// Shared widths and types of the page load controller.
// Assumes a 15-bit byte address space and byte-wide data.
package plc_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } load_t;
endpackage

// File: rtl/plc_strobe.sv
// Strobe decoder: turns the ce_n/we_n/oe_n handshake into one load event.
// It takes the address when the write condition opens (the later enable
// falling edge) and the data in the final active cycle (the earlier rising
// edge). Assumes the strobes are synchronous to clk. When en is low, any new
// cycle is not armed and no load or we-fall is reported.
module plc_strobe
    import plc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              we_fall,
    output logic              ld_valid,
    output load_t             ld
);
    logic              wr_act;
    logic              act_q;
    logic              we_q;
    logic              pend;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign wr_act   = !ce_n && !we_n && oe_n;
    assign we_fall  = en && !we_n && we_q;
    assign ld_valid = en && pend && act_q && !wr_act;
    assign ld.addr  = addr_q;
    assign ld.data  = data_q;

    // Track the previous strobe state and capture the address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            we_q   <= 1'b1;
            pend   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            act_q <= wr_act;
            we_q  <= we_n;
            if (wr_act && !act_q) begin
                pend   <= en;
                addr_q <= addr;
            end else if (!wr_act && act_q) begin
                pend <= 1'b0;
            end
            if (wr_act) begin
                data_q <= din;
            end
        end
    end
endmodule

// File: rtl/plc_countdown.sv
// Retriggerable one-shot timer. A start pulse (re)loads SPAN. fire is high
// in the cycle whose clock edge ends a run of exactly SPAN cycles. A start
// in that same cycle takes priority and restarts the run.
module plc_countdown #(
    parameter int unsigned SPAN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run,
    output logic fire
);
    localparam int CW = $clog2(SPAN + 1);

    logic [CW-1:0] cnt;

    assign fire = run && (cnt == CW'(1)) && !start;

    // Load on start, count down while running, stop on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(SPAN);
        end else if (fire) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/plc_page_buf.sv
// Page buffer: one byte register and valid flag per offset. It records the
// open page number, the sticky foreign-page error and the last accepted
// load. The first load after close starts a fresh page. Assumes a load and
// a close never fall in the same cycle.
module plc_page_buf
    import plc_pkg::*;
#(
    parameter int PAGE_BYTES = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_valid,
    input  load_t                        ld,
    input  logic                         close,
    output logic                         open,
    output logic [PAGE_BYTES*DATA_W-1:0] data,
    output logic [PAGE_BYTES-1:0]        valid,
    output logic [ADDR_W-OFF_W-1:0]      page_id,
    output logic                         err,
    output logic [ADDR_W-1:0]            last_addr,
    output logic [DATA_W-1:0]            last_data
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  off;
    logic [PAGE_W-1:0] pg;
    logic              accept;

    assign off    = ld.addr[OFF_W-1:0];
    assign pg     = ld.addr[ADDR_W-1:OFF_W];
    assign accept = ld_valid && (!open || (pg == page_id));

    // Byte storage, one register per offset.
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[i*DATA_W +: DATA_W] <= '0;
            end else if (accept && (off == OFF_W'(i))) begin
                data[i*DATA_W +: DATA_W] <= ld.data;
            end
        end
    end

    // Page state: open flag, page number, valid flags and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open    <= 1'b0;
            page_id <= '0;
            valid   <= '0;
            err     <= 1'b0;
        end else if (ld_valid && !open) begin
            open    <= 1'b1;
            page_id <= pg;
            valid   <= PAGE_BYTES'(1) << off;
            err     <= 1'b0;
        end else if (ld_valid) begin
            if (accept) begin
                valid[off] <= 1'b1;
            end else begin
                err <= 1'b1;
            end
        end else if (close) begin
            open <= 1'b0;
        end
    end

    // Status copy of the most recent accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (accept) begin
            last_addr <= ld.addr;
            last_data <= ld.data;
        end
    end
endmodule

// File: rtl/page_load_ctrl.sv
// Page-mode write load controller top. It decodes host write strobes, buffers
// one page, closes the page when the load window expires and then times
// the programming phase. Assumes LOAD_WIN is longer than one host write
// cycle, so a page never closes while a load is still in flight.
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int          PAGE_BYTES = 128,
    parameter int unsigned LOAD_WIN   = 5000,
    parameter int unsigned PROG_CYC   = 150000,
    localparam int         OFF_W      = $clog2(PAGE_BYTES),
    localparam int         PAGE_W     = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ce_n,
    input  logic                         we_n,
    input  logic                         oe_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            din,
    output logic [PAGE_BYTES*DATA_W-1:0] page_data,
    output logic [PAGE_BYTES-1:0]        page_valid,
    output logic [PAGE_W-1:0]            commit_page,
    output logic                         commit,
    output logic                         busy,
    output logic                         page_err,
    output logic [ADDR_W-1:0]            last_addr,
    output logic [DATA_W-1:0]            last_data
);
    logic  we_fall;
    logic  ld_valid;
    load_t ld;
    logic  win_run;
    logic  win_fire;
    logic  prog_fire;
    logic  page_open;
    logic  commit_now;

    assign commit_now = win_fire && page_open;

    plc_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!busy),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .din      (din),
        .we_fall  (we_fall),
        .ld_valid (ld_valid),
        .ld       (ld)
    );

    plc_countdown #(.SPAN(LOAD_WIN)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .start (we_fall),
        .run   (win_run),
        .fire  (win_fire)
    );

    plc_countdown #(.SPAN(PROG_CYC)) u_prog (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_now),
        .run   (busy),
        .fire  (prog_fire)
    );

    plc_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld        (ld),
        .close     (commit_now),
        .open      (page_open),
        .data      (page_data),
        .valid     (page_valid),
        .page_id   (commit_page),
        .err       (page_err),
        .last_addr (last_addr),
        .last_data (last_data)
    );

    // One-cycle commit request aligned with the start of busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit <= 1'b0;
        end else begin
            commit <= commit_now;
        end
    end

    logic unused_ok;
    assign unused_ok = win_run ^ prog_fire;
endmodule

// File: rtl/plc_checker.sv
// Protocol checker for page_load_ctrl, attached by bind. It watches only the
// top ports and keeps its own counter for the busy length.
module plc_checker #(
    parameter int          PAGE_BYTES = 128,
    parameter int unsigned PROG_CYC   = 150000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  commit,
    input logic                  busy,
    input logic                  page_err,
    input logic [PAGE_BYTES-1:0] page_valid,
    input logic [14:0]           last_addr,
    input logic [7:0]            last_data
);
    int unsigned busy_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_len <= 0;
        end else begin
            busy_len <= busy_len + 1;
        end
    end

    p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    p_commit_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (page_valid != '0));
    p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> commit);
    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == PROG_CYC));
    p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < PROG_CYC));
    p_frozen_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(page_valid));
    p_frozen_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($stable(last_addr) && $stable(last_data)));
    p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(page_err) |-> ($countones(page_valid) == 1));
endmodule

bind page_load_ctrl plc_checker #(
    .PAGE_BYTES (PAGE_BYTES),
    .PROG_CYC   (PROG_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .busy       (busy),
    .page_err   (page_err),
    .page_valid (page_valid),
    .last_addr  (last_addr),
    .last_data  (last_data)
);

// File: tb/page_load_ctrl_tb.sv
module page_load_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 20;
    localparam int PROG       = 50;
    localparam int NB         = 128;

    typedef struct packed {
        logic [14:0] a;
        logic [7:0]  d;
        logic        ok;
        logic        cem;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{a: 15'h0185, d: 8'hA5, ok: 1'b1, cem: 1'b0},
        '{a: 15'h0186, d: 8'h3C, ok: 1'b1, cem: 1'b1},
        '{a: 15'h0205, d: 8'h77, ok: 1'b0, cem: 1'b0},
        '{a: 15'h0190, d: 8'h11, ok: 1'b1, cem: 1'b1},
        '{a: 15'h01FF, d: 8'hEE, ok: 1'b1, cem: 1'b0},
        '{a: 15'h0185, d: 8'h5A, ok: 1'b1, cem: 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ce_n = 1'b1;
    logic            we_n = 1'b1;
    logic            oe_n = 1'b1;
    logic [14:0]     addr = '0;
    logic [7:0]      din = '0;
    logic [NB*8-1:0] page_data;
    logic [NB-1:0]   page_valid;
    logic [7:0]      commit_page;
    logic            commit;
    logic            busy;
    logic            page_err;
    logic [14:0]     last_addr;
    logic [7:0]      last_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int fall_cyc = 0;
    int commit_cyc = 0;
    int commit_cnt = 0;
    int busy_cnt = 0;
    logic we_prev = 1'b1;
    logic done = 1'b0;

    page_load_ctrl #(.PAGE_BYTES(NB), .LOAD_WIN(WIN), .PROG_CYC(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .page_data(page_data), .page_valid(page_valid),
        .commit_page(commit_page), .commit(commit), .busy(busy),
        .page_err(page_err), .last_addr(last_addr), .last_data(last_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge monitor: numbers clock edges and notes sampled we_n falls.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n && !we_n && we_prev) fall_cyc = cyc;
        we_prev = we_n;
    end

    // Output monitor away from the active edge.
    always @(negedge clk) begin
        if (commit) begin
            commit_cnt = commit_cnt + 1;
            commit_cyc = cyc;
        end
        if (busy) busy_cnt = busy_cnt + 1;
    end

    task automatic check(input logic ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One host write; cem=1 gives a chip-enable controlled cycle.
    task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic cem);
        if (!cem) begin
            @(negedge clk); addr = a; din = d; ce_n = 1'b0;
            @(negedge clk); we_n = 1'b0;
            @(negedge clk); addr = ~a;
            @(negedge clk); we_n = 1'b1; din = ~d;
            @(negedge clk); ce_n = 1'b1;
        end else begin
            @(negedge clk); addr = ~a; din = d; we_n = 1'b0;
            @(negedge clk); addr = a; ce_n = 1'b0;
            @(negedge clk); addr = ~a;
            @(negedge clk); ce_n = 1'b1; din = ~d;
            @(negedge clk); we_n = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic wait_commit(input int start);
        for (int i = 0; i < 500 && commit_cnt == start; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] exp_valid;
        logic [7:0]    exp_mem [NB];
        logic [NB-1:0] old_valid;
        logic [14:0]   old_addr;
        int            c0;

        exp_valid = '0;
        for (int i = 0; i < NB; i++) exp_mem[i] = 8'h00;

        idle(4);
        check(busy == 1'b0, "R8 reset busy", 128'(busy), 0);
        check(commit == 1'b0, "R7 reset commit", 128'(commit), 0);
        check(page_valid == '0, "R4 reset valid", 128'(page_valid), 0);
        check(page_err == 1'b0, "R5 reset err", 128'(page_err), 0);
        rst_n = 1'b1;
        idle(2);

        // Table walk: mixed WE/CE controlled loads, one foreign page.
        for (int v = 0; v < 6; v++) begin
            wr(VECS[v].a, VECS[v].d, VECS[v].cem);
            if (VECS[v].ok) begin
                exp_valid[VECS[v].a[6:0]] = 1'b1;
                exp_mem[VECS[v].a[6:0]] = VECS[v].d;
            end
            check(page_valid == exp_valid, "R4/R5 table valid",
                  128'(page_valid), 128'(exp_valid));
            check(page_err == (v >= 2), "R5 table err", 128'(page_err), 128'(v >= 2));
            check(commit_cnt == 0, "R6 no early commit", 128'(commit_cnt), 0);
        end
        c0 = commit_cnt;
        wait_commit(c0);
        check(commit_cnt == 1, "R7 single commit", 128'(commit_cnt), 1);
        check(commit_cyc - fall_cyc == WIN, "R6 commit delay",
              128'(commit_cyc - fall_cyc), 128'(WIN));
        check(commit_page == 8'h03, "R7 commit page", 128'(commit_page), 128'h03);
        check(page_valid == exp_valid, "R7 valid held", 128'(page_valid), 128'(exp_valid));
        for (int i = 0; i < NB; i++) begin
            if (exp_valid[i]) begin
                check(page_data[i*8 +: 8] == exp_mem[i], "R2/R3 byte",
                      128'(page_data[i*8 +: 8]), 128'(exp_mem[i]));
            end
        end
        check(last_addr == 15'h0185 && last_data == 8'h5A, "R10 last",
              128'({last_addr, last_data}), 128'({15'h0185, 8'h5A}));

        // Strobes during busy are ignored.
        old_valid = page_valid;
        old_addr  = last_addr;
        busy_cnt  = 1;
        wr(15'h0481, 8'h99, 1'b0);
        wait_idle();
        idle(1);
        check(busy_cnt == PROG, "R8 busy length", 128'(busy_cnt), 128'(PROG));
        check(page_valid == old_valid, "R9 valid frozen", 128'(page_valid), 128'(old_valid));
        check(last_addr == old_addr, "R9 last frozen", 128'(last_addr), 128'(old_addr));

        // Output enable low: no write cycle.
        @(negedge clk); oe_n = 1'b0;
        wr(15'h0481, 8'h42, 1'b0);
        @(negedge clk); oe_n = 1'b1;
        check(page_valid == old_valid, "R1 oe low ignored", 128'(page_valid), 128'(old_valid));

        // New page clears error; retrigger after a gap.
        wr(15'h0481, 8'h42, 1'b0);
        check(page_valid == 128'h2, "R4 new page valid", 128'(page_valid), 128'h2);
        check(page_err == 1'b0, "R5 err cleared", 128'(page_err), 0);
        check(last_addr == 15'h0481 && last_data == 8'h42, "R10 last new",
              128'({last_addr, last_data}), 128'({15'h0481, 8'h42}));
        idle(8);
        wr(15'h0482, 8'h43, 1'b1);
        c0 = commit_cnt;
        wait_commit(c0);
        check(commit_cnt == 2, "R6 retrigger one commit", 128'(commit_cnt), 2);
        check(commit_cyc - fall_cyc == WIN, "R6 retrigger delay",
              128'(commit_cyc - fall_cyc), 128'(WIN));
        check(commit_page == 8'h09, "R7 page 9", 128'(commit_page), 128'h09);

        // Full page of 128 bytes.
        wait_idle();
        idle(2);
        for (int i = 0; i < NB; i++) begin
            wr({8'h55, 7'(i)}, 8'(i) ^ 8'h5C, i[0]);
        end
        c0 = commit_cnt;
        wait_commit(c0);
        check(&page_valid, "R11 full valid", 128'(page_valid), {128{1'b1}});
        check(page_data[7:0] == 8'h5C, "R11 byte 0", 128'(page_data[7:0]), 128'h5C);
        check(page_data[64*8 +: 8] == 8'h1C, "R11 byte 64",
              128'(page_data[64*8 +: 8]), 128'h1C);
        check(page_data[127*8 +: 8] == 8'h23, "R11 byte 127",
              128'(page_data[127*8 +: 8]), 128'h23);
        check(commit_page == 8'h55, "R11 page", 128'(commit_page), 128'h55);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule